// File: doc/BRIEF.md
# ECC Page Error Report Aggregator

This block gathers the per-packet results of an ECC decoder over one flash page and condenses them into two 32-bit words that software reads once the transfer has finished. The first packet of a page keeps its own corrected-bit count and success flag. Every later packet is folded into one summary made of the largest corrected-bit count seen and a combined success flag. Alongside the report, the block tracks whether every packet of the page came back as erased data (all bytes 0xFF).

A page begins with a one-cycle start pulse, which clears the accumulated state. The number of packets per page is a run-time input. When the result for the last configured packet has been accepted, the block raises a valid flag and emits a one-cycle done pulse. A combinational read port returns either the report word or the status word.

Top module: `ecc_page_report`

## Requirements
- R1: After reset the report word reads 0x00008080, the status word reads 0x00010000, and report_valid_o and done_o are 0.
- R2: One cycle after page_start_i both count fields read 0, both success bits read 1, the erased flag reads 1 and report_valid_o reads 0. A packet presented in the same cycle as page_start_i is dropped.
- R3: Report bits [5:0] hold the corrected-bit count of packet 0. Report bit 7 is 1 when packet 0 decoded successfully and 0 when it failed.
- R4: Report bits [13:8] hold the largest corrected-bit count among packets 1 onward. This field is a maximum, not a sum.
- R5: Report bit 15 is 1 only when every packet after packet 0 decoded successfully. Any single failure among them clears it.
- R6: Status bit 16 is the erased flag. It is cleared by any accepted packet whose pkt_dirty_i is 1. While the flag is set, both report count fields read 0.
- R7: steps_i sets the number of packets per page, and the packet with index steps_i-1 is the last one. A steps_i value of 0 behaves as 1.
- R8: report_valid_o and status bit 0 rise, and done_o pulses high for exactly one cycle, on the clock edge that accepts the last packet. Packets arriving before the first page start, or after the page has completed, change nothing.
- R9: Report bits [31:16], 14 and 6 read 0. Status bits [31:17] and [15:1] read 0.
- R10: rd_data_o returns the report word when rd_sel_i is 0 and the status word when rd_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_start_i | input | 1 | Start-of-page pulse; clears all page state |
| steps_i | input | STEP_W | Number of packets per page |
| pkt_valid_i | input | 1 | Strobe for a packet result |
| pkt_cnt_i | input | 6 | Corrected-bit count of the packet |
| pkt_ok_i | input | 1 | Packet decoded successfully |
| pkt_dirty_i | input | 1 | Raw packet data held at least one byte other than 0xFF |
| rd_sel_i | input | 1 | Read select: 0 selects the report word, 1 selects the status word |
| rd_data_o | output | 32 | Selected word |
| report_valid_o | output | 1 | Report is complete for the current page |
| done_o | output | 1 | One-cycle pulse when the page completes |

## Verification
Each accepted packet updates the report one clock edge after its strobe. The cycle after the last packet's strobe carries done_o, report_valid_o and the final words, and done_o has dropped again one cycle later. The bench drives inputs on the falling edge. Before it drives each later packet, it samples that done_o is still low. After the final packet it checks the pulse, the flag and both words. On the next falling edge it checks that the pulse has ended. The read port is combinational, so each word is sampled in the same half-cycle in which rd_sel_i changes.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int CNT_W  = 6;
  localparam int LANE_W = 8;
  localparam int WORD_W = 32;
  localparam int PAD_W  = LANE_W - CNT_W - 1;
endpackage

// File: rtl/ecc_pkt_seq.sv
module ecc_pkt_seq #(
  parameter int STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic              acc_first_o,
  output logic              acc_rest_o,
  output logic              done_o,
  output logic              rvalid_o
);
  logic              busy_q;
  logic [STEP_W-1:0] idx_q;
  logic [STEP_W-1:0] last_idx;
  logic              accept;
  logic              is_last;

  // steps of 0 behaves as a one-packet page
  assign last_idx    = (steps_i == '0) ? '0 : steps_i - 1'b1;
  assign accept      = valid_i && busy_q && !start_i;
  assign is_last     = (idx_q == last_idx);
  assign acc_first_o = accept && (idx_q == '0);
  assign acc_rest_o  = accept && (idx_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      done_o   <= 1'b0;
      rvalid_o <= 1'b0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      idx_q    <= '0;
      done_o   <= 1'b0;
      rvalid_o <= 1'b0;
    end else if (accept) begin
      idx_q <= idx_q + 1'b1;
      if (is_last) begin
        busy_q   <= 1'b0;
        done_o   <= 1'b1;
        rvalid_o <= 1'b1;
      end else begin
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_i));
endmodule

// File: rtl/ecc_pkt_fold.sv
module ecc_pkt_fold
  import ecc_rpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             acc_first_i,
  input  logic             acc_rest_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt0_o,
  output logic             ok0_o,
  output logic [CNT_W-1:0] cntn_o,
  output logic             okn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt0_o <= '0;
      ok0_o  <= 1'b1;
      cntn_o <= '0;
      okn_o  <= 1'b1;
    end else if (start_i) begin
      cnt0_o <= '0;
      ok0_o  <= 1'b1;
      cntn_o <= '0;
      okn_o  <= 1'b1;
    end else begin
      if (acc_first_i) begin
        cnt0_o <= cnt_i;
        ok0_o  <= ok_i;
      end
      if (acc_rest_i) begin
        if (cnt_i > cntn_o) cntn_o <= cnt_i;
        okn_o <= okn_o & ok_i;
      end
    end
  end

  a_r4_max_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> cntn_o >= $past(cntn_o));
  a_r5_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(okn_o) |-> $past(acc_rest_i && !ok_i));
  a_r3_first_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !acc_first_i) |=> ($stable(cnt0_o) && $stable(ok0_o)));
endmodule

// File: rtl/ecc_erase_track.sv
module ecc_erase_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic acc_i,
  input  logic dirty_i,
  output logic empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                empty_o <= 1'b1;
    else if (start_i)           empty_o <= 1'b1;
    else if (acc_i && dirty_i)  empty_o <= 1'b0;
  end

  a_r6_rise_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(start_i));
  a_r6_clear_on_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(acc_i && dirty_i));
endmodule

// File: rtl/ecc_page_report.sv
module ecc_page_report
  import ecc_rpt_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_start_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              pkt_valid_i,
  input  logic [CNT_W-1:0]  pkt_cnt_i,
  input  logic              pkt_ok_i,
  input  logic              pkt_dirty_i,
  input  logic              rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              report_valid_o,
  output logic              done_o
);
  logic             acc_first, acc_rest;
  logic [CNT_W-1:0] cnt0, cntn, cnt0_m, cntn_m;
  logic             ok0, okn, empty;
  logic [WORD_W-1:0] rpt_word, sts_word;

  ecc_pkt_seq #(.STEP_W(STEP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (page_start_i),
    .valid_i     (pkt_valid_i),
    .steps_i     (steps_i),
    .acc_first_o (acc_first),
    .acc_rest_o  (acc_rest),
    .done_o      (done_o),
    .rvalid_o    (report_valid_o)
  );

  ecc_pkt_fold u_fold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (page_start_i),
    .acc_first_i (acc_first),
    .acc_rest_i  (acc_rest),
    .cnt_i       (pkt_cnt_i),
    .ok_i        (pkt_ok_i),
    .cnt0_o      (cnt0),
    .ok0_o       (ok0),
    .cntn_o      (cntn),
    .okn_o       (okn)
  );

  ecc_erase_track u_erase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (page_start_i),
    .acc_i   (acc_first | acc_rest),
    .dirty_i (pkt_dirty_i),
    .empty_o (empty)
  );

  // erased page: counts carry no meaning
  assign cnt0_m = empty ? '0 : cnt0;
  assign cntn_m = empty ? '0 : cntn;

  assign rpt_word = {{(WORD_W-2*LANE_W){1'b0}},
                     okn, {PAD_W{1'b0}}, cntn_m,
                     ok0, {PAD_W{1'b0}}, cnt0_m};
  assign sts_word = {{(WORD_W-2*LANE_W-1){1'b0}}, empty,
                     {(2*LANE_W-1){1'b0}}, report_valid_o};

  assign rd_data_o = rd_sel_i ? sts_word : rpt_word;

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_start_i |=> (rpt_word == 32'h0000_8080 && empty && !report_valid_o));
  a_r6_erased_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> (rpt_word[13:8] == '0 && rpt_word[5:0] == '0));
endmodule

// File: tb/tb_ecc_page_report.sv
`timescale 1ns/1ps
module tb_ecc_page_report;
  localparam int STEP_W = 8;

  logic              clk, rst_n;
  logic              page_start, pkt_valid, pkt_ok, pkt_dirty, rd_sel;
  logic [STEP_W-1:0] steps;
  logic [5:0]        pkt_cnt;
  logic [31:0]       rd_data;
  logic              rvalid, done;

  ecc_page_report #(.STEP_W(STEP_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .page_start_i(page_start), .steps_i(steps),
    .pkt_valid_i(pkt_valid), .pkt_cnt_i(pkt_cnt), .pkt_ok_i(pkt_ok),
    .pkt_dirty_i(pkt_dirty), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .report_valid_o(rvalid), .done_o(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // packet byte: [7]=dirty [6]=ok [5:0]=count; packet i at pkts[8i+:8]
  typedef struct packed {
    logic [2:0]  n;
    logic [31:0] pkts;
    logic [31:0] rpt;
    logic [31:0] sts;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd1, 32'h0000_00C5, 32'h0000_8085, 32'h0000_0001},  // R3 single packet
    '{3'd4, 32'hC9C2_C7C3, 32'h0000_8983, 32'h0000_0001},  // R4 max
    '{3'd3, 32'h0081_C4BF, 32'h0000_043F, 32'h0000_0001},  // R5 failures
    '{3'd2, 32'h0000_0206, 32'h0000_0000, 32'h0001_0001},  // R6 erased
    '{3'd0, 32'h0000_00C1, 32'h0000_8081, 32'h0000_0001},  // R7 steps 0
    '{3'd2, 32'h0000_DF40, 32'h0000_9F80, 32'h0000_0001},  // R6 clean pkt0, dirty pkt1
    '{3'd4, 32'hC1C5_E0C0, 32'h0000_A080, 32'h0000_0001}   // R4 max not sum
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [31:0] rpt, input logic [31:0] sts);
    rd_sel = 1'b0; #1; chk({req, " R10 report"}, rd_data, rpt);
    rd_sel = 1'b1; #1; chk({req, " R10 status"}, rd_data, sts);
    rd_sel = 1'b0;
  endtask

  task automatic start_page(input logic [STEP_W-1:0] s);
    @(negedge clk);
    steps = s; page_start = 1'b1;
    @(negedge clk);
    page_start = 1'b0;
  endtask

  task automatic drive_pkt(input logic [7:0] b);
    pkt_valid = 1'b1; pkt_dirty = b[7]; pkt_ok = b[6]; pkt_cnt = b[5:0];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; page_start = 0; pkt_valid = 0; pkt_ok = 0; pkt_dirty = 0;
    pkt_cnt = '0; rd_sel = 0; steps = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_check("R1", 32'h0000_8080, 32'h0001_0000);
    chk("R1 valid", {31'b0, rvalid}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);

    // R8 packet before any page start is ignored
    drive_pkt(8'hBF);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk("R8 idle done", {31'b0, done}, 32'd0);
    rd_check("R8 idle", 32'h0000_8080, 32'h0001_0000);

    // vector table
    foreach (VECS[v]) begin
      int n;
      n = (VECS[v].n == 0) ? 1 : int'(VECS[v].n);
      start_page({5'b0, VECS[v].n});
      for (int i = 0; i < n; i++) begin
        if (i > 0) chk("R7 done early", {31'b0, done}, 32'd0);
        drive_pkt(VECS[v].pkts[8*i +: 8]);
        @(negedge clk);
      end
      pkt_valid = 1'b0;
      chk("R8 done pulse", {31'b0, done}, 32'd1);
      chk("R8 valid", {31'b0, rvalid}, 32'd1);
      rd_check("R3 R4 R5 R6 R9 vector", VECS[v].rpt, VECS[v].sts);
      @(negedge clk);
      chk("R8 done width", {31'b0, done}, 32'd0);
    end

    // R8 packet after completion is ignored
    drive_pkt(8'hBF);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk("R8 post done", {31'b0, done}, 32'd0);
    rd_check("R8 post", 32'h0000_A080, 32'h0000_0001);

    // R2 start clears, packet on start cycle dropped
    @(negedge clk);
    steps = 8'd2; page_start = 1'b1; drive_pkt(8'hBF);
    @(negedge clk);
    page_start = 1'b0; pkt_valid = 1'b0;
    rd_check("R2 clear", 32'h0000_8080, 32'h0001_0000);
    chk("R2 valid low", {31'b0, rvalid}, 32'd0);
    // dropped packet means two more are still needed
    drive_pkt(8'hC2);
    @(negedge clk);
    chk("R2 not done after one", {31'b0, done}, 32'd0);
    rd_check("R3 partial", 32'h0000_8082, 32'h0000_0000);
    drive_pkt(8'h45);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk("R2 done after two", {31'b0, done}, 32'd1);
    rd_check("R4 R5 clean rest", 32'h0000_8582, 32'h0000_0001);

    // R2 restart mid-page
    start_page(8'd3);
    drive_pkt(8'h85);
    @(negedge clk);
    pkt_valid = 1'b0;
    start_page(8'd1);
    rd_check("R2 restart", 32'h0000_8080, 32'h0001_0000);

    @(negedge clk);
    finish_run();
  end
endmodule